// File: doc/BRIEF.md
# Dual-Thread Replay Instruction Buffer

This block is a two-thread instruction queue. It sits between a fetch front-end and an in-order issue back-end. Each thread owns a circular region of `DEPTH` entries. An entry holds an instruction word, its fetch address and a parity bit supplied by fetch. An entry stays in the buffer after it issues, until the back-end commits it. Because of this, a back-end data error can be recovered by rewinding the thread's issue position and reissuing, with no refetch. The write side fills one thread per cycle with up to `WR_W` instructions. The issue side reads one thread per cycle, with up to `ISS_W` instructions. The two sides choose their threads independently.

A parity mismatch on an instruction read for issue means the buffer contents are damaged. That thread then drops all its uncommitted entries. The block asserts a flush for that thread and asks fetch to refetch from the address of the oldest uncommitted instruction.

Each thread runs a two-state machine. In `T_RUN` the thread accepts writes and issues normally. In `T_FLUSH` the thread lasts exactly one cycle, drives its flush and refetch outputs, and neither accepts writes nor issues. The transition `T_RUN -> T_FLUSH` happens on a parity fault. The transition `T_FLUSH -> T_RUN` is unconditional. Reset places both threads in `T_RUN`.

Top module: `ibuf_replay_top`

## Requirements
- R1: After reset both regions are empty. `wr_ready` is high for both threads, `iss_cnt` is 0 for any request, and `flush_o` and `refetch_o` are low.
- R2: When `wr_valid` is high and the selected thread is ready, slots 0 to `wr_cnt`-1 of the write bus are appended to that thread in slot order. Slot i is stored with address `wr_addr`+i. An appended entry can issue from the next cycle on.
- R3: In the same cycle as the request, `iss_cnt` equals the smaller of `iss_req` and the number of held but not yet issued entries of thread `iss_tid`. Issue slot j carries the j-th oldest such entry (instruction and address), so each thread issues strictly in program order.
- R4: The write side and the issue side may select different threads in the same cycle, and both operations take effect.
- R5: `wr_ready[t]` is low exactly when fewer than `WR_W` entries of thread t are free, or when t is in `T_FLUSH`. A write to a thread that is not ready has no effect.
- R6: A commit of `cm_cnt` entries (never more than are issued and uncommitted) frees the oldest entries of thread `cm_tid`, starting from the next cycle.
- R7: A replay request rewinds thread `rp_tid` so that its next issue starts again at its oldest uncommitted entry, with no refetch. An issue from the same thread in the replay cycle is suppressed (`iss_cnt` = 0).
- R8: When commit and replay target the same thread in the same cycle, the commit is applied first, and the rewind goes to the entry that is oldest after that commit.
- R9: The parity bit of an entry must equal the XOR of its instruction bits. If any of the entries granted in a cycle mismatches, `iss_cnt` is 0 in that cycle. In the next cycle `flush_o[t]` and `refetch_o[t]` are high for exactly one cycle, with `refetch_addr` slice t holding the address of the oldest entry left uncommitted after that cycle's commit. All uncommitted entries of t, including a write in the fault cycle, are dropped.
- R10: A flush of one thread leaves the other thread's entries, issue position and readiness unchanged, and the two flush outputs are never high together.
- R11: Each region is used circularly, so order and contents are kept across the wrap from the last entry to the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Fetch group present |
| wr_tid | input | $clog2(NT) | Thread of the fetch group |
| wr_cnt | input | $clog2(WR_W+1) | Number of valid slots in the group |
| wr_addr | input | AW | Address of slot 0 |
| wr_instr | input | WR_W*DW | Instruction slots, slot i at bits i*DW |
| wr_par | input | WR_W | Parity bit per slot |
| wr_ready | output | NT | Per-thread write acceptance |
| iss_tid | input | $clog2(NT) | Thread chosen for issue |
| iss_req | input | $clog2(ISS_W+1) | Instructions wanted this cycle |
| iss_cnt | output | $clog2(ISS_W+1) | Instructions issued this cycle |
| iss_instr | output | ISS_W*DW | Issued instructions, slot j at bits j*DW |
| iss_addr | output | ISS_W*AW | Addresses of issued instructions |
| cm_valid | input | 1 | Commit present |
| cm_tid | input | $clog2(NT) | Committing thread |
| cm_cnt | input | $clog2(ISS_W+1) | Entries committed |
| rp_valid | input | 1 | Back-end replay request |
| rp_tid | input | $clog2(NT) | Thread to rewind |
| flush_o | output | NT | Per-thread one-cycle flush |
| refetch_o | output | NT | Per-thread one-cycle refetch request |
| refetch_addr | output | NT*AW | Refetch address per thread |

## Verification
The issue result (`iss_cnt` and the slot contents) is combinational. It is due in the same cycle as the request, and it reflects writes, commits and replays made up to the previous clock edge. `wr_ready` is also due in the same cycle, from the registered occupancy. Flush, refetch and the refetch address come from registers. They appear in the cycle after the faulting readout and are gone one cycle later. The bench drives inputs at the falling edge, checks the combinational results 1 ns later, and updates its queue model at the rising edge. It compares the registered outputs at the next falling edge, so each result is sampled in exactly the cycle it is due.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    typedef enum logic [0:0] {
        T_RUN   = 1'b0,
        T_FLUSH = 1'b1
    } tstate_e;

    // position v folded back into a ring of size d (v < 2*d)
    function automatic int ring_wrap(input int v, input int d);
        return (v >= d) ? v - d : v;
    endfunction

endpackage

// File: rtl/ibuf_thread_ctl.sv
module ibuf_thread_ctl
    import ibuf_pkg::*;
#(
    parameter int DEPTH = 96,
    parameter int WR_W  = 6,
    parameter int ISS_W = 12,
    parameter int AW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_acc,
    input  logic [$clog2(WR_W+1)-1:0]    wr_n,
    input  logic [$clog2(ISS_W+1)-1:0]   iss_n,
    input  logic                         perr,
    input  logic [$clog2(ISS_W+1)-1:0]   cm_n,
    input  logic                         rp,
    input  logic [AW-1:0]                head_addr,
    output logic [$clog2(DEPTH)-1:0]     cmt_nxt,
    output logic [$clog2(DEPTH)-1:0]     wptr,
    output logic [$clog2(DEPTH)-1:0]     iptr,
    output logic [$clog2(DEPTH+1)-1:0]   avail,
    output logic                         ready,
    output logic                         running,
    output logic                         flush_o,
    output logic                         refetch_o,
    output logic [AW-1:0]                refetch_addr
);
    localparam int IXW = $clog2(DEPTH);
    localparam int PW  = $clog2(DEPTH+1);

    tstate_e          st_q, st_n;
    logic [IXW-1:0]   cmt_q;
    logic [PW-1:0]    ntot_q, niss_q, ntot_n, niss_n;

    // ring positions derived from the commit head and two occupancy counts
    always_comb begin
        wptr    = IXW'(ring_wrap(int'(cmt_q) + int'(ntot_q), DEPTH));
        iptr    = IXW'(ring_wrap(int'(cmt_q) + int'(niss_q), DEPTH));
        cmt_nxt = IXW'(ring_wrap(int'(cmt_q) + int'(cm_n), DEPTH));
        avail   = ntot_q - niss_q;
    end

    // occupancy update: write and issue add, commit removes, then rewind/flush
    always_comb begin
        ntot_n = ntot_q + (wr_acc ? PW'(wr_n) : '0) - PW'(cm_n);
        niss_n = niss_q + PW'(iss_n) - PW'(cm_n);
        if (rp) niss_n = '0;
        if (perr) begin
            ntot_n = '0;
            niss_n = '0;
        end
    end

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            T_RUN:   if (perr) st_n = T_FLUSH;
            T_FLUSH: st_n = T_RUN;
            default: st_n = T_RUN;
        endcase
    end

    // state register and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= T_RUN;
            cmt_q  <= '0;
            ntot_q <= '0;
            niss_q <= '0;
        end else begin
            st_q   <= st_n;
            cmt_q  <= cmt_nxt;
            ntot_q <= ntot_n;
            niss_q <= niss_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    refetch_addr <= '0;
        else if (perr) refetch_addr <= head_addr;
    end

    // outputs
    always_comb begin
        running   = (st_q == T_RUN);
        flush_o   = (st_q == T_FLUSH);
        refetch_o = (st_q == T_FLUSH);
        ready     = running && (ntot_q <= PW'(DEPTH - WR_W));
    end

    // R5
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ntot_q <= PW'(DEPTH));

    // R3
    issue_behind_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        niss_q <= ntot_q);

    // R6
    commit_within_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
        PW'(cm_n) <= niss_q);

    // R7
    rewind_to_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rp && !perr) |=> (niss_q == '0));

    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (ntot_q == '0 && niss_q == '0));

    // R9
    flush_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

endmodule

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
#(
    parameter int NT    = 2,
    parameter int DEPTH = 96,
    parameter int WR_W  = 6,
    parameter int ISS_W = 12,
    parameter int DW    = 16,
    parameter int AW    = 32
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [$clog2(NT)-1:0]         w_tid,
    input  logic [$clog2(DEPTH)-1:0]      w_base,
    input  logic [$clog2(WR_W+1)-1:0]     w_n,
    input  logic [AW-1:0]                 w_addr,
    input  logic [WR_W*DW-1:0]            w_instr,
    input  logic [WR_W-1:0]               w_par,
    input  logic [$clog2(NT)-1:0]         r_tid,
    input  logic [$clog2(DEPTH)-1:0]      r_base,
    output logic [ISS_W*DW-1:0]           r_instr,
    output logic [ISS_W*AW-1:0]           r_addr,
    output logic [ISS_W-1:0]              r_bad,
    input  logic [NT*$clog2(DEPTH)-1:0]   h_idx,
    output logic [NT*AW-1:0]              h_addr
);
    localparam int IXW = $clog2(DEPTH);
    localparam int EN  = NT * DEPTH;
    localparam int EW  = $clog2(EN);

    logic [DW-1:0] m_instr [EN];
    logic [AW-1:0] m_addr  [EN];
    logic          m_par   [EN];

    logic [EW-1:0] widx [WR_W];
    logic [EW-1:0] ridx [ISS_W];

    always_comb begin
        for (int i = 0; i < WR_W; i++)
            widx[i] = EW'(int'(w_tid) * DEPTH + ring_wrap(int'(w_base) + i, DEPTH));
        for (int j = 0; j < ISS_W; j++)
            ridx[j] = EW'(int'(r_tid) * DEPTH + ring_wrap(int'(r_base) + j, DEPTH));
    end

    generate
        for (genvar i = 0; i < WR_W; i++) begin : g_wr
            always_ff @(posedge clk) begin
                if (we && (i < int'(w_n))) begin
                    m_instr[widx[i]] <= w_instr[i*DW +: DW];
                    m_addr[widx[i]]  <= w_addr + AW'(i);
                    m_par[widx[i]]   <= w_par[i];
                end
            end
        end

        for (genvar j = 0; j < ISS_W; j++) begin : g_rd
            assign r_instr[j*DW +: DW] = m_instr[ridx[j]];
            assign r_addr[j*AW +: AW]  = m_addr[ridx[j]];
            assign r_bad[j]            = (^m_instr[ridx[j]]) != m_par[ridx[j]];
        end

        for (genvar t = 0; t < NT; t++) begin : g_head
            assign h_addr[t*AW +: AW] =
                m_addr[EW'(t * DEPTH) + EW'(h_idx[t*IXW +: IXW])];
        end
    endgenerate

endmodule

// File: rtl/ibuf_replay_top.sv
module ibuf_replay_top
    import ibuf_pkg::*;
#(
    parameter int NT    = 2,
    parameter int DEPTH = 96,
    parameter int WR_W  = 6,
    parameter int ISS_W = 12,
    parameter int DW    = 16,
    parameter int AW    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [$clog2(NT)-1:0]         wr_tid,
    input  logic [$clog2(WR_W+1)-1:0]     wr_cnt,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WR_W*DW-1:0]            wr_instr,
    input  logic [WR_W-1:0]               wr_par,
    output logic [NT-1:0]                 wr_ready,
    input  logic [$clog2(NT)-1:0]         iss_tid,
    input  logic [$clog2(ISS_W+1)-1:0]    iss_req,
    output logic [$clog2(ISS_W+1)-1:0]    iss_cnt,
    output logic [ISS_W*DW-1:0]           iss_instr,
    output logic [ISS_W*AW-1:0]           iss_addr,
    input  logic                          cm_valid,
    input  logic [$clog2(NT)-1:0]         cm_tid,
    input  logic [$clog2(ISS_W+1)-1:0]    cm_cnt,
    input  logic                          rp_valid,
    input  logic [$clog2(NT)-1:0]         rp_tid,
    output logic [NT-1:0]                 flush_o,
    output logic [NT-1:0]                 refetch_o,
    output logic [NT*AW-1:0]              refetch_addr
);
    localparam int TW  = $clog2(NT);
    localparam int IXW = $clog2(DEPTH);
    localparam int PW  = $clog2(DEPTH+1);
    localparam int ICW = $clog2(ISS_W+1);

    logic [IXW-1:0]     wptr_a [NT];
    logic [IXW-1:0]     iptr_a [NT];
    logic [PW-1:0]      avail_a [NT];
    logic [NT-1:0]      running_a;
    logic [NT*IXW-1:0]  head_idx;
    logic [NT*AW-1:0]   head_addr;
    logic [ISS_W-1:0]   r_bad;
    logic [ICW-1:0]     gnt;
    logic               perr_any;

    // issue grant: in-order, bounded by request and unissued entries
    always_comb begin
        gnt = '0;
        if (running_a[iss_tid] && !(rp_valid && rp_tid == iss_tid)) begin
            if (int'(iss_req) < int'(avail_a[iss_tid])) gnt = iss_req;
            else                                         gnt = ICW'(avail_a[iss_tid]);
        end
        perr_any = 1'b0;
        for (int j = 0; j < ISS_W; j++)
            if (j < int'(gnt) && r_bad[j]) perr_any = 1'b1;
        iss_cnt = perr_any ? '0 : gnt;
    end

    generate
        for (genvar t = 0; t < NT; t++) begin : g_thr
            ibuf_thread_ctl #(
                .DEPTH(DEPTH), .WR_W(WR_W), .ISS_W(ISS_W), .AW(AW)
            ) u_ctl (
                .clk          (clk),
                .rst_n        (rst_n),
                .wr_acc       (wr_valid && wr_tid == TW'(t) && wr_ready[t]),
                .wr_n         (wr_cnt),
                .iss_n        ((iss_tid == TW'(t)) ? iss_cnt : '0),
                .perr         (perr_any && iss_tid == TW'(t)),
                .cm_n         ((cm_valid && cm_tid == TW'(t)) ? cm_cnt : '0),
                .rp           (rp_valid && rp_tid == TW'(t)),
                .head_addr    (head_addr[t*AW +: AW]),
                .cmt_nxt      (head_idx[t*IXW +: IXW]),
                .wptr         (wptr_a[t]),
                .iptr         (iptr_a[t]),
                .avail        (avail_a[t]),
                .ready        (wr_ready[t]),
                .running      (running_a[t]),
                .flush_o      (flush_o[t]),
                .refetch_o    (refetch_o[t]),
                .refetch_addr (refetch_addr[t*AW +: AW])
            );
        end
    endgenerate

    ibuf_store #(
        .NT(NT), .DEPTH(DEPTH), .WR_W(WR_W), .ISS_W(ISS_W), .DW(DW), .AW(AW)
    ) u_store (
        .clk     (clk),
        .we      (wr_valid && wr_ready[wr_tid]),
        .w_tid   (wr_tid),
        .w_base  (wptr_a[wr_tid]),
        .w_n     (wr_cnt),
        .w_addr  (wr_addr),
        .w_instr (wr_instr),
        .w_par   (wr_par),
        .r_tid   (iss_tid),
        .r_base  (iptr_a[iss_tid]),
        .r_instr (iss_instr),
        .r_addr  (iss_addr),
        .r_bad   (r_bad),
        .h_idx   (head_idx),
        .h_addr  (head_addr)
    );

    // R3
    issue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_cnt <= iss_req);

    // R10
    flush_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_o));

    // R9
    refetch_with_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_o == flush_o);

    // R9
    fault_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        perr_any |-> (iss_cnt == '0));

endmodule

// File: tb/ibuf_replay_top_tb.sv
module ibuf_replay_top_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NT = 2, D = 96, WR_W = 6, ISS_W = 12, DW = 16, AW = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [0:0] wr_tid = '0, iss_tid = '0, cm_tid = '0, rp_tid = '0;
    logic [2:0] wr_cnt = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [WR_W*DW-1:0] wr_instr = '0;
    logic [WR_W-1:0] wr_par = '0;
    logic [NT-1:0] wr_ready, flush_o, refetch_o;
    logic [3:0] iss_req = '0, iss_cnt, cm_cnt = '0;
    logic [ISS_W*DW-1:0] iss_instr;
    logic [ISS_W*AW-1:0] iss_addr;
    logic cm_valid = 1'b0, rp_valid = 1'b0;
    logic [NT*AW-1:0] refetch_addr;

    ibuf_replay_top u_dut (.*);

    always #2.5 clk = ~clk;

    // bench model: per-thread queue of uncommitted entries, count issued
    logic [DW-1:0] qi [2][$];
    logic [AW-1:0] qa [2][$];
    bit            qb [2][$];
    int  nis [2];
    bit  fl [2];
    bit  prev_cmrp [2];
    bit  prev_cm [2];
    int  wtot [2];
    logic [AW-1:0] rfa [2];
    int  tests = 0, fails = 0;
    bit  done = 1'b0;

    // knobs
    int k_wr = 50, k_wtid = -1, k_wcnt = -1, k_ireq = -1, k_itid = -1;
    int k_cm = 40, k_rp = 5, k_bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic one_cycle();
        bit er [2];
        int it, g, ecnt, avail;
        bit err, acc;
        string tg;
        @(negedge clk);
        // registered outputs due one cycle after the fault
        for (int t = 0; t < NT; t++) begin
            // R9 flush and refetch; R10 when the other thread is flushing
            chk(flush_o[t] == fl[t] && refetch_o[t] == fl[t],
                fl[1-t] ? "R10 flush isolation" : "R9 flush/refetch",
                flush_o[t], fl[t]);
            if (fl[t])
                chk(refetch_addr[t*AW +: AW] == rfa[t], "R9 refetch address",
                    refetch_addr[t*AW +: AW], rfa[t]);
        end
        // drive
        wr_valid = ($urandom_range(0, 99) < k_wr);
        wr_tid   = (k_wtid < 0) ? 1'($urandom_range(0, 1)) : 1'(k_wtid);
        wr_cnt   = (k_wcnt < 0) ? 3'($urandom_range(0, WR_W)) : 3'(k_wcnt);
        wr_addr  = $urandom();
        for (int i = 0; i < WR_W; i++) begin
            logic [DW-1:0] w;
            w = DW'($urandom());
            wr_instr[i*DW +: DW] = w;
            wr_par[i] = (^w) ^ ($urandom_range(0, 999) < k_bad);
        end
        iss_tid  = (k_itid < 0) ? 1'($urandom_range(0, 1)) : 1'(k_itid);
        iss_req  = (k_ireq < 0) ? 4'($urandom_range(0, ISS_W)) : 4'(k_ireq);
        cm_valid = ($urandom_range(0, 99) < k_cm);
        cm_tid   = 1'($urandom_range(0, 1));
        cm_cnt   = cm_valid ? 4'($urandom_range(0, (nis[cm_tid] < ISS_W) ? nis[cm_tid] : ISS_W)) : '0;
        rp_valid = ($urandom_range(0, 99) < k_rp);
        rp_tid   = 1'($urandom_range(0, 1));
        #1;
        for (int t = 0; t < NT; t++) begin
            er[t] = !fl[t] && ((D - qi[t].size()) >= WR_W);
            // R5 back-pressure; R6 when a commit freed room last cycle
            chk(wr_ready[t] == er[t], prev_cm[t] ? "R6 ready after commit" : "R5 ready",
                wr_ready[t], er[t]);
        end
        it = int'(iss_tid);
        g = 0;
        err = 1'b0;
        avail = qi[it].size() - nis[it];
        if (!fl[it] && !(rp_valid && rp_tid == iss_tid))
            g = (int'(iss_req) < avail) ? int'(iss_req) : avail;
        for (int j = 0; j < g; j++) if (qb[it][nis[it]+j]) err = 1'b1;
        ecnt = err ? 0 : g;
        if (rp_valid && rp_tid == iss_tid) tg = "R7 issue suppressed on replay";
        else if (err)                      tg = "R9 issue blocked on parity";
        else if (prev_cmrp[it])            tg = "R8 commit then replay";
        else if (wr_valid && wr_tid != iss_tid) tg = "R4 split threads";
        else if (wtot[it] > D)             tg = "R11 wrapped region";
        else                               tg = "R3 issue count";
        chk(int'(iss_cnt) == ecnt, tg, iss_cnt, ecnt);
        for (int j = 0; j < ecnt; j++) begin
            chk(iss_instr[j*DW +: DW] == qi[it][nis[it]+j], tg,
                iss_instr[j*DW +: DW], qi[it][nis[it]+j]);
            // R2 stored address is wr_addr + slot
            chk(iss_addr[j*AW +: AW] == qa[it][nis[it]+j], "R2 address",
                iss_addr[j*AW +: AW], qa[it][nis[it]+j]);
        end
        @(posedge clk);
        // model update: write, commit, issue, replay, flush
        acc = wr_valid && er[wr_tid];
        if (acc) begin
            for (int i = 0; i < int'(wr_cnt); i++) begin
                qi[wr_tid].push_back(wr_instr[i*DW +: DW]);
                qa[wr_tid].push_back(wr_addr + AW'(i));
                qb[wr_tid].push_back((^wr_instr[i*DW +: DW]) != wr_par[i]);
            end
            wtot[wr_tid] += int'(wr_cnt);
        end
        for (int t = 0; t < NT; t++) begin
            prev_cm[t] = cm_valid && cm_tid == 1'(t) && cm_cnt != 0;
            prev_cmrp[t] = cm_valid && rp_valid && cm_tid == 1'(t) && rp_tid == 1'(t);
        end
        if (cm_valid) begin
            for (int i = 0; i < int'(cm_cnt); i++) begin
                void'(qi[cm_tid].pop_front());
                void'(qa[cm_tid].pop_front());
                void'(qb[cm_tid].pop_front());
            end
            nis[cm_tid] -= int'(cm_cnt);
        end
        nis[it] += ecnt;
        if (rp_valid) nis[rp_tid] = 0;
        fl[0] = 1'b0;
        fl[1] = 1'b0;
        if (err) begin
            rfa[it] = qa[it][0];
            qi[it].delete();
            qa[it].delete();
            qb[it].delete();
            nis[it] = 0;
            fl[it] = 1'b1;
        end
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) one_cycle();
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        iss_req = 4'd5;
        #1;
        // R1 reset state
        chk(wr_ready == 2'b11, "R1 ready", wr_ready, 3);
        chk(iss_cnt == 0, "R1 issue", iss_cnt, 0);
        chk(flush_o == 0 && refetch_o == 0, "R1 flush", flush_o, 0);
        rst_n = 1'b1;
        // fill thread 0 up to the back-pressure boundary
        k_wr = 100; k_wtid = 0; k_wcnt = WR_W; k_ireq = 0; k_cm = 0; k_rp = 0;
        run(20);
        // write thread 1 while issuing thread 0
        k_wtid = 1; k_itid = 0; k_ireq = -1; k_cm = 60;
        run(30);
        // drain with commits and replays, including same-cycle commit and replay
        k_wr = 30; k_wtid = -1; k_itid = -1; k_cm = 90; k_rp = 20;
        run(200);
        // parity faults
        k_wr = 60; k_bad = 40; k_rp = 5;
        run(300);
        // long mixed run, wraps both regions many times
        k_bad = 3; k_cm = 60; k_wcnt = -1;
        run(3000);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule